// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a single-port synchronous memory. Address, command and write data are all captured on the rising clock edge. A read and a write may be issued on every clock in any mix, with no idle cycle between them. Each command enters a two-stage pipeline. A read returns its word two edges after its command was taken. A write takes its data from the input bus on the edge two after its command. Because read data and write data use the same slot, the bus stays full when traffic alternates between reads and writes.

A command cycle either loads a fresh address or advances a 2-bit burst counter seeded from the two lowest address bits. The counter can step in interleaved (XOR) order or in linear (wrapping increment) order. Per-lane active-low write enables allow partial-word writes. Three chip selects gate whether a loaded command is issued at all. An active-low clock enable freezes the whole block for as long as it is held high.

The data bus is split into lanes of parameterised width. The address depth is also a parameter.

Top module: `pipe_sram`

## Requirements
- R1: After reset, both pipeline slots hold deselect commands. `dataValid` and `dataOut` are 0 until the first read completes.
- R2: A read command taken on edge k drives `dataOut` with the stored word, and sets `dataValid` to 1, after edge k+2.
- R3: A write command taken on edge k stores the value that `dataIn` holds at edge k+2.
- R4: While `clkEnN` is 1 at an edge, all inputs are ignored on that edge. Every internal state keeps its value, and `dataOut` and `dataValid` hold.
- R5: When `loadN`=0, a new address and command are taken. When `loadN`=1, the previous command type continues (a deselect continues as a deselect), the burst step count rises by one, and only address bits [1:0] change.
- R6: When `orderSel`=1 at an advance, the low address bits equal start XOR step, where the start is the loaded bits [1:0] and the step runs from 0 to 3.
- R7: When `orderSel`=0 at an advance, the low address bits equal (start + step) mod 4.
- R8: A command with `writeN`=0 writes lane i (bits [i*LANE_W +: LANE_W]) only when `byteEnN[i]`=0. A write with all `byteEnN` bits at 1 changes nothing but still uses its slot. A read (`writeN`=1) ignores `byteEnN`.
- R9: A loaded command is issued only when `selN`=0, `selHi`=1 and `selLoN`=0. Any other select pattern issues a deselect. A deselect writes nothing, and `dataValid` is 0 in its slot.
- R10: Reads and writes may alternate on consecutive edges with no idle cycle. A read returns every earlier write, including one issued on the edge just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clkEnN | input | 1 | Active-low clock enable; 1 freezes the block |
| selN | input | 1 | Chip select, active low |
| selHi | input | 1 | Chip select, active high |
| selLoN | input | 1 | Second chip select, active low |
| loadN | input | 1 | 0 loads a new address and command, 1 advances the burst |
| writeN | input | 1 | 0 selects write, 1 selects read |
| byteEnN | input | LANES | Per-lane write enables, active low |
| orderSel | input | 1 | 1 selects interleaved burst order, 0 selects linear |
| addrIn | input | ADDR_W | Word address |
| dataIn | input | LANES*LANE_W | Write data, sampled two edges after its command |
| dataOut | output | LANES*LANE_W | Read data |
| dataValid | output | 1 | 1 while dataOut holds the result of a read slot |

## Verification
The bench builds the block with its default parameters: a 64-word depth and two 9-bit lanes. The small depth lets the bench write every word before it starts checking, so each later read has a known expected value. With two lanes, all four enable patterns can be tried, including the aborted write and each single-lane write. The 6-bit address leaves four upper bits that must stay fixed during a burst, while the low two bits wrap through every start value in both orders.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // strobes from control to datapath for the slot at the tail of the pipe
  typedef struct packed {
    logic advance;
    logic doRead;
    logic doWrite;
  } strobe_t;

  function automatic logic [1:0] burstLow(input logic [1:0] start,
                                          input logic [1:0] step,
                                          input logic       interleave);
    return interleave ? (start ^ step) : (start + step);
  endfunction

endpackage

// File: rtl/pipe_sram_ctrl.sv
module pipe_sram_ctrl
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clkEnN,
  input  logic              selN,
  input  logic              selHi,
  input  logic              selLoN,
  input  logic              loadN,
  input  logic              writeN,
  input  logic [LANES-1:0]  byteEnN,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output strobe_t           strobe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  laneMask
);

  localparam int HI_W = ADDR_W - 2;

  op_e             burstOp;
  logic [HI_W-1:0] burstHi;
  logic [1:0]      burstStart;
  logic [1:0]      burstCnt;
  logic [1:0]      nextCnt;

  op_e               issueOp;
  logic [ADDR_W-1:0] issueAddr;
  logic [LANES-1:0]  issueLanes;
  logic              selected;

  op_e               s1Op, s2Op;
  logic [ADDR_W-1:0] s1Addr, s2Addr;
  logic [LANES-1:0]  s1Lanes, s2Lanes;

  assign selected = !selN && selHi && !selLoN;
  assign nextCnt  = burstCnt + 2'd1;

  always_comb begin
    if (!loadN) begin
      if (!selected)   issueOp = OP_IDLE;
      else if (writeN) issueOp = OP_READ;
      else             issueOp = OP_WRITE;
      issueAddr = addrIn;
    end else begin
      issueOp   = burstOp;
      issueAddr = {burstHi, burstLow(burstStart, nextCnt, orderSel)};
    end
    issueLanes = (issueOp == OP_WRITE) ? ~byteEnN : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burstOp    <= OP_IDLE;
      burstHi    <= '0;
      burstStart <= '0;
      burstCnt   <= '0;
      s1Op       <= OP_IDLE;
      s1Addr     <= '0;
      s1Lanes    <= '0;
      s2Op       <= OP_IDLE;
      s2Addr     <= '0;
      s2Lanes    <= '0;
    end else if (!clkEnN) begin
      if (!loadN) begin
        burstOp    <= issueOp;
        burstHi    <= addrIn[ADDR_W-1:2];
        burstStart <= addrIn[1:0];
        burstCnt   <= '0;
      end else begin
        burstCnt   <= nextCnt;
      end
      s1Op    <= issueOp;
      s1Addr  <= issueAddr;
      s1Lanes <= issueLanes;
      s2Op    <= s1Op;
      s2Addr  <= s1Addr;
      s2Lanes <= s1Lanes;
    end
  end

  assign strobe.advance = !clkEnN;
  assign strobe.doRead  = (s2Op == OP_READ);
  assign strobe.doWrite = (s2Op == OP_WRITE) && (|s2Lanes);
  assign memAddr        = s2Addr;
  assign laneMask       = s2Lanes;

endmodule

// File: rtl/pipe_sram_dp.sv
module pipe_sram_dp
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  strobe_t                 strobe,
  input  logic [ADDR_W-1:0]       memAddr,
  input  logic [LANES-1:0]        laneMask,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataValid
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] rdWord;

  for (genvar lane = 0; lane < LANES; lane++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobe.advance && strobe.doWrite && laneMask[lane])
        laneMem[memAddr] <= dataIn[lane*LANE_W +: LANE_W];
    end

    assign rdWord[lane*LANE_W +: LANE_W] = laneMem[memAddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else if (strobe.advance) begin
      dataValid <= strobe.doRead;
      if (strobe.doRead) dataOut <= rdWord;
    end
  end

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clkEnN,
  input  logic                    selN,
  input  logic                    selHi,
  input  logic                    selLoN,
  input  logic                    loadN,
  input  logic                    writeN,
  input  logic [LANES-1:0]        byteEnN,
  input  logic                    orderSel,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataValid
);

  localparam int DATA_W = LANES * LANE_W;

  strobe_t           strobe;
  logic [ADDR_W-1:0] memAddr;
  logic [LANES-1:0]  laneMask;

  pipe_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clkEnN(clkEnN),
    .selN(selN), .selHi(selHi), .selLoN(selLoN),
    .loadN(loadN), .writeN(writeN), .byteEnN(byteEnN),
    .orderSel(orderSel), .addrIn(addrIn),
    .strobe(strobe), .memAddr(memAddr), .laneMask(laneMask)
  );

  pipe_sram_dp #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .memAddr(memAddr), .laneMask(laneMask),
    .dataIn(dataIn[DATA_W-1:0]), .dataOut(dataOut), .dataValid(dataValid)
  );

endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk
  import pipe_sram_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clkEnN,
  input logic              dataValid,
  input logic [DATA_W-1:0] dataOut,
  input strobe_t           strobe
);

  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    clkEnN |=> ($stable(dataOut) && $stable(dataValid))); // R4

  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!clkEnN && strobe.doRead) |=> dataValid); // R2

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!clkEnN && !strobe.doRead) |=> !dataValid); // R9

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.doRead, strobe.doWrite})); // R8

endmodule

bind pipe_sram pipe_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clkEnN(clkEnN),
  .dataValid(dataValid), .dataOut(dataOut), .strobe(strobe)
);

// File: tb/pipe_sram_bench.sv
`timescale 1ns/1ps
module pipe_sram_bench;

  localparam int AW = 6;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clkEnN = 1'b0, selN = 1'b1, selHi = 1'b0, selLoN = 1'b1;
  logic loadN = 1'b0, writeN = 1'b1, orderSel = 1'b1;
  logic [1:0] byteEnN = 2'b11;
  logic [AW-1:0] addrIn = '0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic dataValid;

  always #4 clk = ~clk;

  pipe_sram u_pipe_sram (
    .clk(clk), .rst_n(rst_n), .clkEnN(clkEnN),
    .selN(selN), .selHi(selHi), .selLoN(selLoN),
    .loadN(loadN), .writeN(writeN), .byteEnN(byteEnN),
    .orderSel(orderSel), .addrIn(addrIn), .dataIn(dataIn),
    .dataOut(dataOut), .dataValid(dataValid)
  );

  int checks = 0;
  int errors = 0;
  int cycNo = 0;
  bit done = 0;

  // reference model state
  logic [DW-1:0] refMem [64];
  int pOp[$];
  int pAddr[$];
  int pLanes[$];
  int bOp = 0, bHi = 0, bStart = 0, bCnt = 0;
  logic [DW-1:0] expData = '0;
  logic expValid = 1'b0;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cycNo);
    end
  endtask

  task automatic modelEdge();
    int iop, iaddr, ilanes, xop, xaddr, xl;
    if (clkEnN) return;
    if (!loadN) begin
      iop = (!selN && selHi && !selLoN) ? (writeN ? 1 : 2) : 0;
      iaddr = int'(addrIn);
      bOp = iop; bHi = iaddr / 4; bStart = iaddr % 4; bCnt = 0;
    end else begin
      bCnt = (bCnt + 1) % 4;
      iop = bOp;
      iaddr = bHi * 4 + (orderSel ? (bStart ^ bCnt) : ((bStart + bCnt) % 4));
    end
    ilanes = (iop == 2) ? int'(~byteEnN) & 3 : 0;
    pOp.push_back(iop); pAddr.push_back(iaddr); pLanes.push_back(ilanes);
    xop = pOp.pop_front(); xaddr = pAddr.pop_front(); xl = pLanes.pop_front();
    if (xop == 2) begin
      if (xl[0]) refMem[xaddr][8:0]  = dataIn[8:0];
      if (xl[1]) refMem[xaddr][17:9] = dataIn[17:9];
    end
    expValid = (xop == 1);
    if (xop == 1) expData = refMem[xaddr];
  endtask

  // one clock: inputs already set by caller, fresh write data each cycle
  task automatic tick(input string tag);
    dataIn = DW'(cycNo * 18'h1357 + 18'h0abc);
    modelEdge();
    @(posedge clk);
    @(negedge clk);
    cycNo++;
    check({tag, " valid"}, {17'd0, dataValid}, {17'd0, expValid});
    check({tag, " data"}, dataOut, expData);
  endtask

  task automatic cmd(input logic ld, input logic wr, input int a,
                     input logic [1:0] be, input logic ord, input string tag);
    clkEnN = 0; selN = 0; selHi = 1; selLoN = 0;
    loadN = ld; writeN = wr; addrIn = AW'(a); byteEnN = be; orderSel = ord;
    tick(tag);
  endtask

  task automatic idle(input string tag);
    clkEnN = 0; selN = 1; selHi = 0; selLoN = 1; loadN = 0; writeN = 1;
    tick(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      pOp.push_back(0); pAddr.push_back(0); pLanes.push_back(0);
    end
    for (int i = 0; i < 64; i++) refMem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset valid", {17'd0, dataValid}, 18'd0);
    check("R1 reset data", dataOut, 18'd0);
    rst_n = 1;
    idle("R1"); idle("R1");

    // R3: fill every word with full-width writes
    for (int a = 0; a < 64; a++) cmd(0, 0, a, 2'b00, 1, "R3");
    idle("R3"); idle("R3");

    // R2: plain reads with latency two
    for (int a = 0; a < 8; a++) cmd(0, 1, a * 7, 2'b11, 1, "R2");
    idle("R2"); idle("R2");

    // R10: write then read same word on the very next edge, alternating
    for (int a = 0; a < 6; a++) begin
      cmd(0, 0, 40 + a, 2'b00, 1, "R10");
      cmd(0, 1, 40 + a, 2'b00, 1, "R10");
    end
    idle("R10"); idle("R10");

    // R6: interleaved write burst then read burst, every start value
    for (int s = 0; s < 4; s++) begin
      cmd(0, 0, 16 + s, 2'b00, 1, "R6");
      for (int k = 0; k < 3; k++) cmd(1, 0, 0, 2'b00, 1, "R6");
      cmd(0, 1, 16 + s, 2'b11, 1, "R6");
      for (int k = 0; k < 3; k++) cmd(1, 1, 0, 2'b11, 1, "R6");
    end
    // R7: linear bursts, every start value, read after write
    for (int s = 0; s < 4; s++) begin
      cmd(0, 0, 44 + s, 2'b00, 0, "R7");
      for (int k = 0; k < 3; k++) cmd(1, 0, 0, 2'b00, 0, "R7");
      cmd(0, 1, 44 + s, 2'b11, 0, "R7");
      for (int k = 0; k < 4; k++) cmd(1, 1, 0, 2'b11, 0, "R7");
    end
    idle("R7"); idle("R7");

    // R5: a deselected load keeps advancing as deselect
    clkEnN = 0; selN = 1; selHi = 1; selLoN = 0; loadN = 0; writeN = 0; addrIn = 6'd8; byteEnN = 2'b00;
    tick("R5");
    for (int k = 0; k < 3; k++) begin loadN = 1; tick("R5"); end
    for (int k = 0; k < 4; k++) cmd(0, 1, 8 + k, 2'b11, 1, "R5");
    idle("R5"); idle("R5");

    // R8: single-lane writes, aborted write, read ignoring enables
    cmd(0, 0, 3, 2'b10, 1, "R8");
    cmd(0, 0, 4, 2'b01, 1, "R8");
    cmd(0, 0, 5, 2'b11, 1, "R8");
    cmd(0, 1, 3, 2'b00, 1, "R8");
    cmd(0, 1, 4, 2'b00, 1, "R8");
    cmd(0, 1, 5, 2'b00, 1, "R8");
    idle("R8"); idle("R8");

    // R4: freeze mid-burst with noisy inputs
    cmd(0, 1, 28, 2'b11, 1, "R4");
    cmd(1, 1, 0, 2'b11, 1, "R4");
    for (int k = 0; k < 3; k++) begin
      clkEnN = 1; loadN = 0; writeN = 0; addrIn = 6'd60; byteEnN = 2'b00; selN = 0;
      tick("R4");
    end
    cmd(1, 1, 0, 2'b11, 1, "R4");
    cmd(1, 1, 0, 2'b11, 1, "R4");
    idle("R4"); idle("R4");
    // frozen write must not land
    cmd(0, 1, 60, 2'b11, 1, "R4");
    idle("R4"); idle("R4");

    // R9: each wrong select pattern blocks a write
    for (int p = 0; p < 3; p++) begin
      clkEnN = 0; loadN = 0; writeN = 0; addrIn = 6'd50; byteEnN = 2'b00;
      selN = (p == 0); selHi = (p != 1); selLoN = (p == 2);
      tick("R9");
    end
    cmd(0, 1, 50, 2'b11, 1, "R9");
    idle("R9"); idle("R9");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule